// File: doc/BRIEF.md
# Parallel Multi-Bit CRC Engine

This block computes a cyclic redundancy check over a stream that arrives several bits per clock. Its next state comes from a combinational loop that applies a single-bit shift-and-feedback step once for each input bit, so any polynomial, CRC width and input width chosen by parameter turns into one flat XOR network with no lookup storage.

A start strobe loads the seed value. Each cycle with valid data consumes a chosen number of bits, counted from the first serial bit. This lets a final, partial word close a message. When nothing is valid the state is held. Two registers are kept side by side. One holds the raw shift-register state. The other holds the finished result, which is optionally bit-reversed and then XORed with a constant, so it can be read at any cycle without extra logic delay.

Top module: `crc_core`

## Requirements
- R1: After reset, `crc_raw` equals the INIT parameter and `crc_out` equals the finished form of INIT.
- R2: In a cycle with `in_valid` high, the raw state after the next rising edge equals the bit-serial CRC, using generator POLY (default 0x04C11DB7, written with the top term implied). The serial CRC is run from the prior state over the consumed bits: for each bit, feedback = state MSB XOR bit, then shift left by one, then XOR POLY when feedback is 1.
- R3: With REFIN = 0 the first serial bit is `in_data[DATA_W-1]` and the order runs down to bit 0. With REFIN = 1 the first serial bit is `in_data[0]` and the order runs upward.
- R4: `in_nbits` selects how many bits are consumed, taken from the start of the serial order. The remaining bits of the word have no effect. Values above DATA_W consume DATA_W bits. A value of 0 leaves the state unchanged.
- R5: While `in_valid` and `start` are both low, `crc_raw` and `crc_out` keep their values.
- R6: `start` reseeds the raw state with INIT. If `in_valid` is high in the same cycle, that cycle's bits are processed starting from INIT.
- R7: `crc_out` always equals the raw state, bit-reversed when REFOUT = 1, then XORed with XOROUT.
- R8: Input widths of 1, 8, 32 and 512 bits give the same result for the same serial bit stream. For the ASCII text "123456789", the non-reflected form with INIT all ones and no final XOR yields 0x0376E6E7. The fully reflected form with a final XOR of all ones yields 0xCBF43926.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Reseed the state with INIT |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | DATA_W | Input word |
| in_nbits | input | $clog2(DATA_W+1) | Number of bits to consume from the word |
| crc_raw | output | CRC_W | Raw shift-register state |
| crc_out | output | CRC_W | Finished CRC (reflected and XORed) |

## Verification
A wrong raw state shows on `crc_raw` at the very next edge and never corrects itself, because every later value depends on it. The bench compares both outputs of every instance on every cycle against a bit-serial model, so a bad feedback tap, a reversed bit order or a miscounted partial word is caught in the first cycle it matters. A broken finishing path shows as a mismatch between `crc_out` and the finished raw value in the same cycle. Fixed check values over a known text confirm the polynomial and conventions at all four widths.

// File: rtl/crc_core.sv
module crc_core #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB7,
  parameter logic [CRC_W-1:0] INIT   = '1,
  parameter logic [CRC_W-1:0] XOROUT = '0,
  parameter bit          REFIN  = 1'b0,
  parameter bit          REFOUT = 1'b0,
  localparam int         CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_nbits,
  output logic [CRC_W-1:0]  crc_raw,
  output logic [CRC_W-1:0]  crc_out
);

  function automatic logic [CRC_W-1:0] shift_bits(
    input logic [CRC_W-1:0]  s_in,
    input logic [DATA_W-1:0] d,
    input logic [CNT_W-1:0]  n
  );
    logic [CRC_W-1:0] s;
    logic b, fb;
    s = s_in;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(n)) begin
        b  = REFIN ? d[i] : d[DATA_W-1-i];
        fb = s[CRC_W-1] ^ b;
        s  = {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
    end
    return s;
  endfunction

  function automatic logic [CRC_W-1:0] finish(input logic [CRC_W-1:0] s);
    logic [CRC_W-1:0] r;
    for (int j = 0; j < CRC_W; j++)
      r[j] = REFOUT ? s[CRC_W-1-j] : s[j];
    return r ^ XOROUT;
  endfunction

  logic [CRC_W-1:0] seed, nxt;

  assign seed = start ? INIT : crc_raw;
  assign nxt  = in_valid ? shift_bits(seed, in_data, in_nbits) : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_raw <= INIT;
      crc_out <= finish(INIT);
    end else if (start || in_valid) begin
      crc_raw <= nxt;
      crc_out <= finish(nxt);
    end
  end

endmodule

// File: rtl/crc_core_chk.sv
module crc_core_chk #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 8,
  parameter logic [CRC_W-1:0] INIT   = '1,
  parameter logic [CRC_W-1:0] XOROUT = '0,
  parameter bit          REFOUT = 1'b0,
  localparam int         CNT_W  = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_valid,
  input logic [CNT_W-1:0]  in_nbits,
  input logic [CRC_W-1:0]  crc_raw,
  input logic [CRC_W-1:0]  crc_out
);

  function automatic logic [CRC_W-1:0] fin_of(input logic [CRC_W-1:0] s);
    logic [CRC_W-1:0] r;
    for (int j = 0; j < CRC_W; j++)
      r[j] = REFOUT ? s[CRC_W-1-j] : s[j];
    return r ^ XOROUT;
  endfunction

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> ($stable(crc_raw) && $stable(crc_out)));

  a_r6_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_valid) |=> (crc_raw == INIT));

  a_r4_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !start && in_nbits == '0) |=> $stable(crc_raw));

  a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
    crc_out == fin_of(crc_raw));

endmodule

bind crc_core crc_core_chk #(
  .CRC_W(CRC_W), .DATA_W(DATA_W), .INIT(INIT), .XOROUT(XOROUT), .REFOUT(REFOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .in_nbits(in_nbits), .crc_raw(crc_raw), .crc_out(crc_out)
);

// File: tb/tb_crc_core.sv
module tb_crc_core;
  localparam int NI = 5;
  localparam logic [31:0] P = 32'h04C11DB7;
  localparam int WID [NI] = '{8, 1, 32, 512, 8};
  localparam bit REF [NI] = '{0, 0, 0, 0, 1};
  localparam int CWD [NI] = '{4, 1, 6, 10, 4};
  localparam logic [31:0] XO [NI] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF};

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic         st [NI];
  logic         v  [NI];
  logic [9:0]   nb [NI];
  logic [511:0] dat [NI];
  logic [31:0]  raw [NI];
  logic [31:0]  fin [NI];
  logic [31:0]  mraw [NI];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  crc_core dut (.clk(clk), .rst_n(rst_n), .start(st[0]), .in_valid(v[0]),
    .in_data(dat[0][7:0]), .in_nbits(nb[0][3:0]), .crc_raw(raw[0]), .crc_out(fin[0]));
  crc_core #(.DATA_W(1)) dut_w1 (.clk(clk), .rst_n(rst_n), .start(st[1]), .in_valid(v[1]),
    .in_data(dat[1][0:0]), .in_nbits(nb[1][0:0]), .crc_raw(raw[1]), .crc_out(fin[1]));
  crc_core #(.DATA_W(32)) dut_w32 (.clk(clk), .rst_n(rst_n), .start(st[2]), .in_valid(v[2]),
    .in_data(dat[2][31:0]), .in_nbits(nb[2][5:0]), .crc_raw(raw[2]), .crc_out(fin[2]));
  crc_core #(.DATA_W(512)) dut_w512 (.clk(clk), .rst_n(rst_n), .start(st[3]), .in_valid(v[3]),
    .in_data(dat[3]), .in_nbits(nb[3]), .crc_raw(raw[3]), .crc_out(fin[3]));
  crc_core #(.DATA_W(8), .REFIN(1'b1), .REFOUT(1'b1), .XOROUT(32'hFFFFFFFF)) dut_refl (
    .clk(clk), .rst_n(rst_n), .start(st[4]), .in_valid(v[4]),
    .in_data(dat[4][7:0]), .in_nbits(nb[4][3:0]), .crc_raw(raw[4]), .crc_out(fin[4]));

  function automatic logic [31:0] mstep(logic [31:0] s, logic [511:0] d, int w, int n, bit rf);
    for (int i = 0; i < n; i++) begin
      logic b, fb;
      b  = rf ? d[i] : d[w-1-i];
      fb = s[31] ^ b;
      s  = s << 1;
      if (fb) s = s ^ P;
    end
    return s;
  endfunction

  function automatic logic [31:0] mfin(logic [31:0] s, int k);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = REF[k] ? s[31-j] : s[j];
    return r ^ XO[k];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, int k);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s inst%0d actual=%08h expected=%08h", req, k, act, exp);
    end
  endtask

  task automatic tick();
    for (int k = 0; k < NI; k++) begin
      int n;
      logic [31:0] s;
      n = (int'(nb[k]) > WID[k]) ? WID[k] : int'(nb[k]);
      s = st[k] ? 32'hFFFFFFFF : mraw[k];
      if (v[k]) s = mstep(s, dat[k], WID[k], n, REF[k]);
      mraw[k] = s;
    end
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < NI; k++) begin
      check("R2", raw[k], mraw[k], k);
      check("R7", fin[k], mfin(mraw[k], k), k);
    end
  endtask

  task automatic idle_all();
    for (int k = 0; k < NI; k++) begin
      st[k] = 0; v[k] = 0; nb[k] = '0; dat[k] = '0;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [71:0] sb [NI];
    int pos [NI];
    bit busy;
    idle_all();
    for (int k = 0; k < NI; k++) mraw[k] = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < NI; k++) begin
      check("R1", raw[k], 32'hFFFFFFFF, k);
      check("R1", fin[k], mfin(32'hFFFFFFFF, k), k);
    end

    // R8 / R3: "123456789" at every width, with R6 start on the first chunk
    for (int k = 0; k < NI; k++) begin
      for (int c = 0; c < 9; c++)
        for (int b = 0; b < 8; b++)
          sb[k][c*8+b] = REF[k] ? ((8'h31 + c) >> b) & 1 : ((8'h31 + c) >> (7-b)) & 1;
      pos[k] = 0;
    end
    busy = 1;
    while (busy) begin
      busy = 0;
      for (int k = 0; k < NI; k++) begin
        int n;
        n = 72 - pos[k];
        if (n > WID[k]) n = WID[k];
        st[k] = (pos[k] == 0);
        v[k]  = (n > 0);
        nb[k] = 10'(n);
        dat[k] = '0;
        for (int j = 0; j < n; j++) begin
          if (REF[k]) dat[k][j] = sb[k][pos[k]+j];
          else        dat[k][WID[k]-1-j] = sb[k][pos[k]+j];
        end
        pos[k] += n;
        if (n > 0) busy = 1;
      end
      if (busy) tick();
    end
    for (int k = 0; k < 4; k++) check("R8", fin[k], 32'h0376E6E7, k);
    check("R8", fin[4], 32'hCBF43926, 4);

    // R5: hold with nothing valid
    idle_all();
    repeat (3) tick();

    // R4: partial words, zero counts and clamped counts; R6: random restarts
    for (int c = 0; c < 1500; c++) begin
      for (int k = 0; k < NI; k++) begin
        int r;
        st[k] = ($urandom_range(15) == 0);
        v[k]  = ($urandom_range(3) != 0);
        r = $urandom_range(3);
        if (r == 0) nb[k] = 10'($urandom_range((1 << CWD[k]) - 1));
        else if (r == 1) nb[k] = 10'($urandom_range(WID[k]));
        else nb[k] = 10'(WID[k]);
        for (int j = 0; j < 16; j++) dat[k][j*32 +: 32] = $urandom;
      end
      tick();
    end
    idle_all();
    tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule